// File: doc/BRIEF.md
# Interrupt Stack Readback Loader

This block collects status words for a line-interface controller and queues them in a small first-in, first-out interrupt stack that the host drains one entry at a time. The host writes a command word whose bits name status registers (received embedded-operations word, M4 overhead bits, M5/M6 overhead bits, activation indication, general status). Each named register's current value is copied into the stack, whether or not it has changed since the last copy. Every command bit clears itself once its copy has been queued.

Three on-chip events also queue entries on their own: a newly validated embedded-operations message while the line is superframe-synchronised, the block-error counter reaching its programmed limit, and a readback of the fixed identification code. All requests share one queue through a fixed priority arbiter that grants one push per cycle. A 4-bit tag travels with each 12-bit word so the host can tell where the word came from. A not-empty queue raises the interrupt request. A sticky flag records any push lost to a full queue. A reset command bit clears the block and places it in power-down.

Top module: `irq_stack_loader`

## Requirements
- R1: Command bits are cmd_bits[0] EOC (tag 1, value reg_eoc), [1] M4 (tag 2, reg_m4), [2] M56 (tag 3, reg_m56), [3] ACT (tag 4, reg_act), [4] STATUS (tag 5, reg_status). Each bit set in a write (cmd_wr high) queues one entry holding the register's value at push time, even when that value equals the previously queued one.
- R2: Requests pending together are pushed one per cycle, lowest tag first. The first entry of a command write is visible two clock edges after the write edge.
- R3: Command bits clear themselves: each write yields exactly one entry per set bit, and nothing more follows.
- R4: When eoc_new pulses while line_synced is high, one entry with tag 6 and the value of reg_eoc is queued. When line_synced is low, eoc_new is ignored.
- R5: When bec_count goes from below bec_limit to at or above it, one entry with tag 7 holding bec_count is queued. Staying at or above the limit queues nothing more. A bec_limit of zero disables this source.
- R6: A pulse on id_read queues the word 12'hC08 with tag 8.
- R7: The stack holds 8 entries and returns them in push order. The head appears on out_word/out_tag, and pop removes it.
- R8: A push into a full stack (with no pop in the same cycle) is dropped and sets overflow. Overflow then stays high until a reset command.
- R9: A write with cmd_bits[5] (RST) empties the stack, clears overflow and all pending requests, ignores the other bits of that write, and sets power_down. The next write without RST clears power_down.
- R10: irq is high exactly when the stack holds at least one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_bits | input | 6 | Command bits: [4:0] snapshot requests, [5] reset |
| reg_eoc | input | 12 | Received embedded-operations register value |
| reg_m4 | input | 12 | M4 overhead register value |
| reg_m56 | input | 12 | M5/M6 overhead register value |
| reg_act | input | 12 | Activation indication register value |
| reg_status | input | 12 | General status register value |
| line_synced | input | 1 | Line fully activated and superframe-synchronised |
| eoc_new | input | 1 | Pulse: new validated embedded-operations message |
| bec_count | input | 12 | Block-error counter value |
| bec_limit | input | 12 | Block-error alarm limit, 0 disables |
| id_read | input | 1 | Pulse: identification readback request |
| pop | input | 1 | Remove head entry |
| out_word | output | 12 | Head entry data |
| out_tag | output | 4 | Head entry source tag |
| irq | output | 1 | Interrupt request, stack not empty |
| overflow | output | 1 | Sticky lost-push flag |
| power_down | output | 1 | Set by the reset command |

## Verification
The hardest situation to reach is a push that arrives while the stack is full with no pop, together with the order in which several sources that became pending in the same cycle leave the arbiter. The bench reaches the full case by issuing two five-bit command writes back to back without popping, which gives ten pushes into eight slots. It then drains the stack and checks that the first eight entries are exactly those expected. Ordering is covered by sweeping all 31 non-empty command patterns, each with distinct register values, and by one write that coincides with an event and an identification pulse in the same cycle.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
    localparam int SRC_N  = 8;
    localparam int CMD_N  = 5;
    localparam int IDX_W  = 3;
    localparam logic [11:0] ID_CODE = 12'hC08;

    typedef enum logic [IDX_W-1:0] {
        SRC_EOC_CMD  = 3'd0,
        SRC_M4       = 3'd1,
        SRC_M56      = 3'd2,
        SRC_ACT      = 3'd3,
        SRC_STATUS   = 3'd4,
        SRC_EOC_EVT  = 3'd5,
        SRC_BEC      = 3'd6,
        SRC_ID       = 3'd7
    } src_e;
endpackage

// File: rtl/irqs_arb.sv
module irqs_arb #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_chain
            assign grant[gi]  = req[gi] & ~seen[gi];
            assign seen[gi+1] = seen[gi] | req[gi];
        end
    endgenerate

    assign any = seen[N];

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irqs_fifo.sv
module irqs_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full,
    output logic          drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wr;
        logic [AW-1:0]            rd;
        logic [CW-1:0]            cnt;
    } fifo_t;

    fifo_t q, d;
    logic do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        d       = q;
        do_pop  = pop && (q.cnt != '0);
        do_push = push && ((q.cnt != CW'(DEPTH)) || do_pop);
        drop    = push && !do_push;
        if (do_push) begin
            d.mem[q.wr] = din;
            d.wr        = bump(q.wr);
        end
        if (do_pop) begin
            d.rd = bump(q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
        if (clr) begin
            d.wr  = '0;
            d.rd  = '0;
            d.cnt = '0;
            drop  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout  = q.mem[q.rd];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
endmodule

// File: rtl/irq_stack_loader.sv
module irq_stack_loader #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 12,
    parameter int TAG_W  = 4,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [5:0]        cmd_bits,
    input  logic [WORD_W-1:0] reg_eoc,
    input  logic [WORD_W-1:0] reg_m4,
    input  logic [WORD_W-1:0] reg_m56,
    input  logic [WORD_W-1:0] reg_act,
    input  logic [WORD_W-1:0] reg_status,
    input  logic              line_synced,
    input  logic              eoc_new,
    input  logic [CNT_W-1:0]  bec_count,
    input  logic [CNT_W-1:0]  bec_limit,
    input  logic              id_read,
    input  logic              pop,
    output logic [WORD_W-1:0] out_word,
    output logic [TAG_W-1:0]  out_tag,
    output logic              irq,
    output logic              overflow,
    output logic              power_down
);
    import irqs_pkg::*;

    localparam int ENTRY_W = WORD_W + TAG_W;

    typedef struct packed {
        logic [SRC_N-1:0] pend;
        logic             reached;
        logic             ovf;
        logic             pd;
    } ctl_t;

    ctl_t q, d;

    logic [SRC_N-1:0]   grant;
    logic [SRC_N-1:0]   new_req;
    logic [IDX_W-1:0]   sel;
    logic               push;
    logic               rst_cmd;
    logic               reached_now;
    logic [WORD_W-1:0]  push_word;
    logic [ENTRY_W-1:0] push_entry;
    logic [ENTRY_W-1:0] head;
    logic               fifo_empty;
    logic               fifo_full;
    logic               fifo_drop;
    logic [SRC_N-1:0]   pend_now;

    irqs_arb #(.N(SRC_N), .IW(IDX_W)) u_arb (
        .req   (q.pend),
        .grant (grant),
        .idx   (sel),
        .any   (push)
    );

    always_comb begin
        case (src_e'(sel))
            SRC_EOC_CMD: push_word = reg_eoc;
            SRC_M4:      push_word = reg_m4;
            SRC_M56:     push_word = reg_m56;
            SRC_ACT:     push_word = reg_act;
            SRC_STATUS:  push_word = reg_status;
            SRC_EOC_EVT: push_word = reg_eoc;
            SRC_BEC:     push_word = WORD_W'(bec_count);
            default:     push_word = WORD_W'(ID_CODE);
        endcase
        push_entry = {TAG_W'(sel) + TAG_W'(1), push_word};
    end

    always_comb begin
        d           = q;
        rst_cmd     = cmd_wr && cmd_bits[5];
        reached_now = (bec_limit != '0) && (bec_count >= bec_limit);
        new_req     = '0;
        if (cmd_wr && !rst_cmd) begin
            new_req[CMD_N-1:0] = cmd_bits[CMD_N-1:0];
        end
        new_req[SRC_EOC_EVT] = eoc_new && line_synced;
        new_req[SRC_BEC]     = reached_now && !q.reached;
        new_req[SRC_ID]      = id_read;

        d.reached = reached_now;
        d.pend    = (q.pend & ~grant) | new_req;
        d.ovf     = q.ovf | fifo_drop;
        if (cmd_wr) begin
            d.pd = rst_cmd;
        end
        if (rst_cmd) begin
            d.pend = '0;
            d.ovf  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    irqs_fifo #(.DEPTH(DEPTH), .DW(ENTRY_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rst_cmd),
        .push  (push),
        .din   (push_entry),
        .pop   (pop),
        .dout  (head),
        .empty (fifo_empty),
        .full  (fifo_full),
        .drop  (fifo_drop)
    );

    assign pend_now   = q.pend;
    assign out_word   = head[WORD_W-1:0];
    assign out_tag    = head[ENTRY_W-1:WORD_W];
    assign irq        = !fifo_empty;
    assign overflow   = q.ovf;
    assign power_down = q.pd;
endmodule

// File: rtl/irqs_chk.sv
module irqs_chk #(
    parameter int TAG_W = 4,
    parameter int SRC_N = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_wr,
    input logic [5:0]       cmd_bits,
    input logic             pop,
    input logic             irq,
    input logic             overflow,
    input logic             power_down,
    input logic [TAG_W-1:0] out_tag,
    input logic             push,
    input logic             fifo_full,
    input logic [SRC_N-1:0] grant,
    input logic [SRC_N-1:0] pend_now
);
    a_r9_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_bits[5]) |=> (!irq && !overflow && power_down));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !(cmd_wr && cmd_bits[5])) |=> overflow);

    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fifo_full && !pop && !(cmd_wr && cmd_bits[5])) |=> overflow);

    a_r1_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (out_tag >= TAG_W'(1) && out_tag <= TAG_W'(SRC_N)));

    a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_bits[5] && cmd_bits[0] && pend_now == '0 && !irq)
        |=> ##1 (irq || power_down));

    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(push));
endmodule

bind irq_stack_loader irqs_chk #(.TAG_W(TAG_W), .SRC_N(irqs_pkg::SRC_N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .cmd_bits   (cmd_bits),
    .pop        (pop),
    .irq        (irq),
    .overflow   (overflow),
    .power_down (power_down),
    .out_tag    (out_tag),
    .push       (push),
    .fifo_full  (fifo_full),
    .grant      (grant),
    .pend_now   (pend_now)
);

// File: tb/irq_stack_loader_test.sv
`timescale 1ns/1ps
module irq_stack_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [5:0]  cmd_bits = '0;
    logic [11:0] reg_eoc = '0, reg_m4 = '0, reg_m56 = '0, reg_act = '0, reg_status = '0;
    logic        line_synced = 1'b0;
    logic        eoc_new = 1'b0;
    logic [11:0] bec_count = '0, bec_limit = '0;
    logic        id_read = 1'b0;
    logic        pop = 1'b0;
    logic [11:0] out_word;
    logic [3:0]  out_tag;
    logic        irq, overflow, power_down;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [11:0] exp_w [0:15];
    logic [3:0]  exp_t [0:15];
    int n_exp = 0;

    always #2.5 clk = ~clk;

    irq_stack_loader uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_bits(cmd_bits),
        .reg_eoc(reg_eoc), .reg_m4(reg_m4), .reg_m56(reg_m56), .reg_act(reg_act),
        .reg_status(reg_status), .line_synced(line_synced), .eoc_new(eoc_new),
        .bec_count(bec_count), .bec_limit(bec_limit), .id_read(id_read), .pop(pop),
        .out_word(out_word), .out_tag(out_tag), .irq(irq), .overflow(overflow),
        .power_down(power_down)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic expect_entry(input logic [11:0] w, input logic [3:0] t);
        exp_w[n_exp] = w;
        exp_t[n_exp] = t;
        n_exp++;
    endtask

    task automatic cmd(input logic [5:0] b);
        cmd_wr = 1'b1;
        cmd_bits = b;
        step(1);
        cmd_wr = 1'b0;
        cmd_bits = '0;
    endtask

    task automatic drain(input string req);
        for (int k = 0; k < n_exp; k++) begin
            check({req, " R10 irq"}, irq, 1'b1);
            check({req, " R7 word"}, out_word, exp_w[k]);
            check({req, " R7 tag"}, out_tag, exp_t[k]);
            pop = 1'b1;
            step(1);
            pop = 1'b0;
        end
        step(3);
        check({req, " R3 R10 empty after drain"}, irq, 1'b0);
        n_exp = 0;
    endtask

    function automatic logic [11:0] regval(input int b, input int m);
        return 12'(((b + 1) << 8) + m);
    endfunction

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R10 reset irq", irq, 1'b0);
        check("R8 reset overflow", overflow, 1'b0);
        check("R9 reset power_down", power_down, 1'b0);

        // R2 latency: entry appears on the second edge after the write edge
        reg_eoc = 12'h0AB;
        cmd(6'h01);
        check("R2 not yet", irq, 1'b0);
        step(1);
        check("R2 two edges", irq, 1'b1);
        expect_entry(12'h0AB, 4'd1);
        drain("R2");

        // R1 R2 R3: every non-empty command pattern
        for (int m = 1; m < 32; m++) begin
            reg_eoc = regval(0, m); reg_m4 = regval(1, m); reg_m56 = regval(2, m);
            reg_act = regval(3, m); reg_status = regval(4, m);
            for (int b = 0; b < 5; b++)
                if (m[b]) expect_entry(regval(b, m), 4'(b + 1));
            cmd(6'(m));
            step(8);
            drain("R1 R2 sweep");
        end

        // R1 unchanged value queued twice
        reg_m4 = 12'h777;
        cmd(6'h02);
        step(2);
        cmd(6'h02);
        step(4);
        expect_entry(12'h777, 4'd2);
        expect_entry(12'h777, 4'd2);
        drain("R1 unchanged");

        // R4 unsynchronised eoc_new ignored, then synchronised
        reg_eoc = 12'h3C3;
        line_synced = 1'b0;
        eoc_new = 1'b1; step(1); eoc_new = 1'b0;
        step(4);
        check("R4 unsynced ignored", irq, 1'b0);
        line_synced = 1'b1;
        eoc_new = 1'b1; step(1); eoc_new = 1'b0;
        step(4);
        expect_entry(12'h3C3, 4'd6);
        drain("R4");

        // R5 block-error limit
        bec_limit = 12'd0; bec_count = 12'd50;
        step(4);
        check("R5 limit zero disables", irq, 1'b0);
        bec_limit = 12'd5; bec_count = 12'd3;
        step(4);
        check("R5 below limit", irq, 1'b0);
        bec_count = 12'd5;
        step(4);
        expect_entry(12'd5, 4'd7);
        drain("R5 reach");
        bec_count = 12'd6;
        step(4);
        check("R5 no repeat", irq, 1'b0);
        bec_count = 12'd2;
        step(2);
        bec_count = 12'd7;
        step(4);
        expect_entry(12'd7, 4'd7);
        drain("R5 recross");
        bec_limit = 12'd0; bec_count = 12'd0;
        step(2);

        // R6 identification
        id_read = 1'b1; step(1); id_read = 1'b0;
        step(3);
        expect_entry(12'hC08, 4'd8);
        drain("R6");

        // R2 mixed priority in one cycle
        reg_eoc = 12'h111; reg_status = 12'h555;
        cmd_wr = 1'b1; cmd_bits = 6'h11; id_read = 1'b1; eoc_new = 1'b1;
        step(1);
        cmd_wr = 1'b0; cmd_bits = '0; id_read = 1'b0; eoc_new = 1'b0;
        step(8);
        expect_entry(12'h111, 4'd1);
        expect_entry(12'h555, 4'd5);
        expect_entry(12'h111, 4'd6);
        expect_entry(12'hC08, 4'd8);
        drain("R2 mixed");

        // R8 overflow: ten pushes into eight slots
        reg_eoc = 12'h0E0; reg_m4 = 12'h0E1; reg_m56 = 12'h0E2;
        reg_act = 12'h0E3; reg_status = 12'h0E4;
        cmd(6'h1F);
        step(7);
        check("R8 no overflow at five", overflow, 1'b0);
        cmd(6'h1F);
        step(7);
        check("R8 overflow set", overflow, 1'b1);
        for (int r = 0; r < 2; r++)
            for (int b = 0; b < 5; b++)
                if (r * 5 + b < 8) expect_entry(12'h0E0 + 12'(b), 4'(b + 1));
        drain("R7 R8 full");
        check("R8 sticky after drain", overflow, 1'b1);

        // R9 reset command
        cmd(6'h03);
        step(4);
        check("R9 pre-reset filled", irq, 1'b1);
        cmd(6'h21);
        check("R9 stack emptied", irq, 1'b0);
        check("R9 overflow cleared", overflow, 1'b0);
        check("R9 power_down set", power_down, 1'b1);
        step(4);
        check("R9 other bits ignored", irq, 1'b0);
        reg_act = 12'h4A4;
        cmd(6'h08);
        check("R9 power_down cleared", power_down, 1'b0);
        step(3);
        expect_entry(12'h4A4, 4'd4);
        drain("R9 after");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule